// File: doc/BRIEF.md
# Multi-Stream Stride Prefetcher

This block sits beside a cache and watches the stream of demand accesses. Each access carries a line address and a stream tag (the tag of the instruction that issued it). For every tag the block keeps a small tracker holding the last line seen, a candidate stride, a confidence count and how far ahead prefetching has already run. Once a tag shows the same nonzero line delta three times in a row, the tracker starts issuing prefetch requests one stride beyond the newest demand line. It keeps going until it is a bounded number of lines ahead. Every further demand access on the same stride lets it issue one more request.

Trackers are allocated by least-recently-used replacement when a tag arrives that no tracker holds. The trackers that have work pending share one prefetch request port, which offers at most one request per cycle under a valid/ready handshake. When more than one tracker is waiting, they take turns in round-robin order. Deltas use two's-complement arithmetic, so descending streams work the same way as ascending ones.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `pf_valid` is 0, and no tracker keeps any history across reset.
- R2: A tag whose accesses form b, b+N, b+2N, b+3N (N nonzero, in lines) starts prefetching at b+4N on the access to b+3N. Later requests step by N, so lines between elements are skipped.
- R3: A trained tracker runs at most 12 requests ahead of its newest demand line. With `pf_ready` held high, training yields exactly 12 requests. Each later matching access yields exactly one more, at demand+12N.
- R4: An access whose delta differs from the stored stride stops that tracker's prefetching and stores the new delta as the candidate. Prefetching resumes only after the new delta has been seen three times in a row.
- R5: A stride of zero never produces a prefetch request, however often it repeats.
- R6: Negative strides work. A descending progression prefetches at decreasing addresses, computed modulo 2^ADDR_W.
- R7: There are eight trackers. An unknown tag takes the tracker whose last access is oldest, and that tracker's previous history is lost.
- R8: When several trackers have pending requests, one request is granted per cycle in round-robin order, so two busy streams alternate.
- R9: While `pf_valid` is high and `pf_ready` is low, and no access arrives, `pf_valid` stays high and `pf_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Demand access present this cycle |
| acc_addr | input | ADDR_W | Demand line address |
| acc_id | input | ID_W | Stream tag of the demand access |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Line address of the offered prefetch |
| pf_ready | input | 1 | Consumer accepts the offered prefetch |

## Verification
The bench builds the block with its defaults: eight trackers, a 12-line lookahead, three matching deltas to train, 32-bit line addresses and 6-bit tags. With eight trackers, a ninth tag is enough to force an eviction, so the bench can compare an evicted stream against a surviving one. The 12-line cap is small enough to drain completely in a short window after each access, which makes the exact number of requests and the first and last address after each access predictable. Holding `pf_ready` low lets two trained streams build up pending work. The bench uses this to observe the stall behaviour and the round-robin alternation when the port is released.

// File: rtl/stride_pf_pkg.sv
// Package: shared defaults and index helpers for the stride prefetcher.
// Assumes index counts are at least 2, so index widths are at least 1.
package stride_pf_pkg;

    localparam int unsigned DEF_STREAMS    = 8;
    localparam int unsigned DEF_MAX_AHEAD  = 12;
    localparam int unsigned DEF_TRAIN_HITS = 3;

    // Circular successor of an index in a ring of n entries.
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/stride_pf_tracker.sv
// Module: one stream tracker.
// Holds the last demand line, the candidate stride, a confidence count and
// the lookahead state for a single stream tag. Invariant once trained:
// next_q == last_q + (ahead_q + 1) * stride_q.
// Assumes that alloc_i and hit_i are never high together, and that grant_i
// only arrives while pending_o is high.
module stride_pf_tracker #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned ID_W       = 6,
    parameter int unsigned TRAIN_HITS = 3,
    parameter int unsigned MAX_AHEAD  = 12,
    localparam int unsigned CONF_W    = $clog2(TRAIN_HITS + 1),
    localparam int unsigned AHEAD_W   = $clog2(MAX_AHEAD + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic               hit_i,
    input  logic               grant_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    input  logic [ID_W-1:0]    acc_id_i,
    output logic               valid_o,
    output logic [ID_W-1:0]    id_o,
    output logic               pending_o,
    output logic [ADDR_W-1:0]  pf_addr_o,
    output logic [AHEAD_W-1:0] ahead_o
);

    logic               valid_q;
    logic [ID_W-1:0]    id_q;
    logic [ADDR_W-1:0]  last_q;
    logic [ADDR_W-1:0]  stride_q;
    logic [CONF_W-1:0]  conf_q;
    logic [AHEAD_W-1:0] ahead_q;
    logic [ADDR_W-1:0]  next_q;

    logic [ADDR_W-1:0]  delta;
    logic               trained;

    // Delta of the new access and training status.
    always_comb begin
        delta   = acc_addr_i - last_q;
        trained = (conf_q == CONF_W'(TRAIN_HITS));
    end

    // Tracker state: allocation, demand update, then issue bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            id_q     <= '0;
            last_q   <= '0;
            stride_q <= '0;
            conf_q   <= '0;
            ahead_q  <= '0;
            next_q   <= '0;
        end else if (alloc_i) begin
            valid_q  <= 1'b1;
            id_q     <= acc_id_i;
            last_q   <= acc_addr_i;
            stride_q <= '0;
            conf_q   <= '0;
            ahead_q  <= '0;
            next_q   <= acc_addr_i;
        end else if (hit_i) begin
            last_q <= acc_addr_i;
            if (delta != stride_q) begin
                stride_q <= delta;
                conf_q   <= CONF_W'(1);
                ahead_q  <= '0;
            end else if (conf_q == CONF_W'(TRAIN_HITS - 1)) begin
                conf_q  <= CONF_W'(TRAIN_HITS);
                ahead_q <= '0;
                next_q  <= acc_addr_i + stride_q;
            end else if (trained) begin
                if (ahead_q == '0) begin
                    next_q <= next_q + stride_q;
                end else if (grant_i) begin
                    next_q <= next_q + stride_q;
                end else begin
                    ahead_q <= ahead_q - AHEAD_W'(1);
                end
            end else begin
                conf_q <= conf_q + CONF_W'(1);
            end
        end else if (grant_i) begin
            next_q  <= next_q + stride_q;
            ahead_q <= ahead_q + AHEAD_W'(1);
        end
    end

    // Request when trained on a nonzero stride and below the lookahead cap.
    always_comb begin
        pending_o = valid_q && trained && (stride_q != '0) &&
                    (ahead_q < AHEAD_W'(MAX_AHEAD));
        valid_o   = valid_q;
        id_o      = id_q;
        pf_addr_o = next_q;
        ahead_o   = ahead_q;
    end

endmodule

// File: rtl/stride_pf_lru.sv
// Module: least-recently-used ordering of the trackers.
// Each entry holds a distinct rank; rank 0 is the most recent and rank N-1
// the victim. Assumes touch_i has at most one bit set.
module stride_pf_lru #(
    parameter int unsigned N      = 8,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] touch_i,
    output logic [N-1:0] victim_o
);

    logic [IDX_W-1:0] rank_q [N];
    logic [IDX_W-1:0] touched_rank;

    // Rank of the entry being touched this cycle.
    always_comb begin
        touched_rank = '0;
        for (int i = 0; i < N; i++) begin
            if (touch_i[i]) touched_rank = rank_q[i];
        end
    end

    // Victim flag: the entry holding the oldest rank.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            victim_o[i] = (rank_q[i] == IDX_W'(N - 1));
        end
    end

    // Rank update: touched entry becomes newest, younger entries age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
        end else if (|touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (touch_i[i]) begin
                    rank_q[i] <= '0;
                end else if (rank_q[i] < touched_rank) begin
                    rank_q[i] <= rank_q[i] + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/stride_pf_rr_arb.sv
// Module: round-robin arbiter for tracker requests.
// The search starts at the pointer, and the pointer moves past the winner
// whenever a grant is taken. Assumes N >= 2.
module stride_pf_rr_arb
    import stride_pf_pkg::*;
#(
    parameter int unsigned N      = 8,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         advance_i,
    output logic [N-1:0] grant_o
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] win_idx;

    // Pick the first request at or after the pointer.
    always_comb begin
        int unsigned idx;
        logic        found;
        grant_o = '0;
        win_idx = '0;
        found   = 1'b0;
        for (int unsigned k = 0; k < N; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req_i[idx]) begin
                grant_o[idx] = 1'b1;
                win_idx      = IDX_W'(idx);
                found        = 1'b1;
            end
        end
    end

    // Pointer moves to the entry after the winner on each accepted grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance_i) begin
            ptr_q <= IDX_W'(ring_next(int'(win_idx), N));
        end
    end

endmodule

// File: rtl/stride_prefetcher.sv
// Module: multi-stream stride prefetcher, top level.
// Matches each demand access to a tracker by stream tag, or allocates the
// least-recently-used tracker. Trackers with pending prefetches share one
// valid/ready request port through a round-robin arbiter.
// Assumes acc_addr is a line address, so a stride of 1 means the next line.
module stride_prefetcher
    import stride_pf_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = DEF_STREAMS,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ID_W        = 6,
    parameter int unsigned TRAIN_HITS  = DEF_TRAIN_HITS,
    parameter int unsigned MAX_AHEAD   = DEF_MAX_AHEAD,
    localparam int unsigned AHEAD_W    = $clog2(MAX_AHEAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ID_W-1:0]   acc_id,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_ready
);

    logic [NUM_STREAMS-1:0]         trk_valid;
    logic [NUM_STREAMS-1:0]         trk_pending;
    logic [ID_W-1:0]                trk_id    [NUM_STREAMS];
    logic [ADDR_W-1:0]              trk_pf    [NUM_STREAMS];
    logic [AHEAD_W-1:0]             trk_ahead [NUM_STREAMS];
    logic [NUM_STREAMS*AHEAD_W-1:0] ahead_flat;

    logic [NUM_STREAMS-1:0] hit_vec;
    logic [NUM_STREAMS-1:0] alloc_vec;
    logic [NUM_STREAMS-1:0] victim;
    logic [NUM_STREAMS-1:0] grant;
    logic                   handshake;

    // Tag match against every live tracker, and allocation on a miss.
    always_comb begin
        for (int i = 0; i < NUM_STREAMS; i++) begin
            hit_vec[i] = acc_valid && trk_valid[i] && (trk_id[i] == acc_id);
        end
        alloc_vec = (acc_valid && !(|hit_vec)) ? victim : '0;
    end

    // Request port: offer the granted tracker's next line.
    always_comb begin
        pf_valid  = |trk_pending;
        handshake = pf_valid && pf_ready;
        pf_addr   = '0;
        for (int i = 0; i < NUM_STREAMS; i++) begin
            if (grant[i]) pf_addr = pf_addr | trk_pf[i];
        end
    end

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_trk
        stride_pf_tracker #(
            .ADDR_W     (ADDR_W),
            .ID_W       (ID_W),
            .TRAIN_HITS (TRAIN_HITS),
            .MAX_AHEAD  (MAX_AHEAD)
        ) u_trk (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_i    (alloc_vec[g]),
            .hit_i      (hit_vec[g]),
            .grant_i    (grant[g] && pf_ready),
            .acc_addr_i (acc_addr),
            .acc_id_i   (acc_id),
            .valid_o    (trk_valid[g]),
            .id_o       (trk_id[g]),
            .pending_o  (trk_pending[g]),
            .pf_addr_o  (trk_pf[g]),
            .ahead_o    (trk_ahead[g])
        );
        assign ahead_flat[g*AHEAD_W +: AHEAD_W] = trk_ahead[g];
    end

    stride_pf_lru #(
        .N        (NUM_STREAMS)
    ) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch_i  (hit_vec | alloc_vec),
        .victim_o (victim)
    );

    stride_pf_rr_arb #(
        .N         (NUM_STREAMS)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (trk_pending),
        .advance_i (handshake),
        .grant_o   (grant)
    );

endmodule

// File: rtl/stride_pf_checker.sv
// Module: property checker bound to the stride prefetcher top.
// Observes the request port, the arbiter grant and every tracker's lookahead.
module stride_pf_checker #(
    parameter int unsigned NUM_STREAMS = 8,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned AHEAD_W     = 4,
    parameter int unsigned MAX_AHEAD   = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           acc_valid,
    input logic                           pf_valid,
    input logic                           pf_ready,
    input logic [ADDR_W-1:0]              pf_addr,
    input logic [NUM_STREAMS-1:0]         grant,
    input logic [NUM_STREAMS*AHEAD_W-1:0] ahead_flat
);

    logic in_rst_q;

    // Remembers whether the previous edge saw reset.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst_q |-> !pf_valid);  // R1

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !acc_valid) |=> (pf_valid && $stable(pf_addr)));  // R9

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));  // R8

    AST_GRANT_MATCHES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid == (grant != '0));  // R8

    // Lookahead cap on every tracker.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NUM_STREAMS; i++) begin
                AST_AHEAD_CAP: assert (ahead_flat[i*AHEAD_W +: AHEAD_W] <= AHEAD_W'(MAX_AHEAD));  // R3
            end
        end
    end

endmodule

bind stride_prefetcher stride_pf_checker #(
    .NUM_STREAMS (NUM_STREAMS),
    .ADDR_W      (ADDR_W),
    .AHEAD_W     (AHEAD_W),
    .MAX_AHEAD   (MAX_AHEAD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .grant      (grant),
    .ahead_flat (ahead_flat)
);

// File: tb/sim_stride_prefetcher.sv
// Bench: a vector table walked by one loop, then directed tests.
module sim_stride_prefetcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [5:0]  acc_id = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;
    logic        pf_ready = 1'b1;

    int nchk = 0;
    int nfail = 0;
    int pf_cnt = 0;
    logic [31:0] pf_log [0:1023];

    always #10 clk = ~clk;  // 50 MHz

    stride_prefetcher u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_id    (acc_id),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr),
        .pf_ready  (pf_ready)
    );

    // Monitor: log every accepted prefetch, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && pf_valid && pf_ready) begin
            pf_log[pf_cnt % 1024] = pf_addr;
            pf_cnt = pf_cnt + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  req;
        logic [7:0]  id;
        logic [31:0] addr;
        logic [7:0]  cnt;
        logic [31:0] first;
        logic [31:0] last;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 8'd5, 32'd100, 8'd0,  32'd0,   32'd0},    // R2 start
        '{8'd2, 8'd5, 32'd104, 8'd0,  32'd0,   32'd0},    // R2 one delta
        '{8'd2, 8'd5, 32'd108, 8'd0,  32'd0,   32'd0},    // R2 two deltas
        '{8'd3, 8'd5, 32'd112, 8'd12, 32'd116, 32'd160},  // R2 b+4N, R3 cap of 12
        '{8'd3, 8'd5, 32'd116, 8'd1,  32'd164, 32'd164},  // R3 one more
        '{8'd3, 8'd5, 32'd120, 8'd1,  32'd168, 32'd168},  // R3 one more
        '{8'd4, 8'd5, 32'd121, 8'd0,  32'd0,   32'd0},    // R4 delta changes
        '{8'd4, 8'd5, 32'd122, 8'd0,  32'd0,   32'd0},    // R4 second match
        '{8'd4, 8'd5, 32'd123, 8'd12, 32'd124, 32'd135},  // R4 retrained
        '{8'd6, 8'd9, 32'd500, 8'd0,  32'd0,   32'd0},    // R6 descending
        '{8'd6, 8'd9, 32'd490, 8'd0,  32'd0,   32'd0},    // R6
        '{8'd6, 8'd9, 32'd480, 8'd0,  32'd0,   32'd0},    // R6
        '{8'd6, 8'd9, 32'd470, 8'd12, 32'd460, 32'd350},  // R6 stride -10
        '{8'd6, 8'd9, 32'd460, 8'd1,  32'd340, 32'd340},  // R6 refill
        '{8'd5, 8'd3, 32'd50,  8'd0,  32'd0,   32'd0},    // R5 zero stride
        '{8'd5, 8'd3, 32'd50,  8'd0,  32'd0,   32'd0},    // R5
        '{8'd5, 8'd3, 32'd50,  8'd0,  32'd0,   32'd0},    // R5
        '{8'd5, 8'd3, 32'd50,  8'd0,  32'd0,   32'd0},    // R5 still nothing
        '{8'd3, 8'd5, 32'd124, 8'd1,  32'd136, 32'd136}   // R3 stream kept
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0;
        acc_valid = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    task automatic access(input logic [5:0] id, input logic [31:0] addr);
        @(posedge clk); #2;
        acc_valid = 1'b1;
        acc_id = id;
        acc_addr = addr;
        @(posedge clk); #2;
        acc_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        logic [5:0] first_side;
        logic alternates;
        // R1: reset state
        do_reset();
        check("R1 pf_valid after reset", {31'd0, pf_valid}, 32'd0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            base = pf_cnt;
            access(VEC[v].id[5:0], VEC[v].addr);
            settle(20);
            check($sformatf("R%0d vec %0d count", VEC[v].req, v), 32'(pf_cnt - base), 32'(VEC[v].cnt));
            if (VEC[v].cnt != 0) begin
                check($sformatf("R%0d vec %0d first", VEC[v].req, v), pf_log[base % 1024], VEC[v].first);
                check($sformatf("R%0d vec %0d last", VEC[v].req, v),
                      pf_log[(base + int'(VEC[v].cnt) - 1) % 1024], VEC[v].last);
            end
        end

        // R7: eight distinct tags keep a partly trained stream alive
        do_reset();
        access(6'd20, 32'd0); access(6'd20, 32'd8); access(6'd20, 32'd16);
        for (int k = 0; k < 7; k++) access(6'(30 + k), 32'(2000 + 64 * k));
        base = pf_cnt;
        access(6'd20, 32'd24);
        settle(20);
        check("R7 survivor trains", 32'(pf_cnt - base), 32'd12);
        check("R7 survivor first", pf_log[base % 1024], 32'd32);

        // R7: a ninth tag evicts the oldest stream
        do_reset();
        access(6'd20, 32'd0); access(6'd20, 32'd8); access(6'd20, 32'd16);
        for (int k = 0; k < 8; k++) access(6'(30 + k), 32'(2000 + 64 * k));
        base = pf_cnt;
        access(6'd20, 32'd24);
        settle(20);
        check("R7 evicted history lost", 32'(pf_cnt - base), 32'd0);

        // R9 and R8: two streams stall, then share the port
        do_reset();
        pf_ready = 1'b0;
        for (int k = 0; k < 4; k++) access(6'd1, 32'(1000 + k));
        for (int k = 0; k < 4; k++) access(6'd2, 32'(5000 + 2 * k));
        settle(3);
        check("R9 valid under stall", {31'd0, pf_valid}, 32'd1);
        base = int'(pf_addr);
        settle(6);
        check("R9 valid held", {31'd0, pf_valid}, 32'd1);
        check("R9 addr held", pf_addr, 32'(base));
        base = pf_cnt;
        pf_ready = 1'b1;
        settle(40);
        check("R8 total served", 32'(pf_cnt - base), 32'd24);
        alternates = 1'b1;
        for (int k = 1; k < 24; k++) begin
            if ((pf_log[(base + k) % 1024] >= 32'd4000) == (pf_log[(base + k - 1) % 1024] >= 32'd4000))
                alternates = 1'b0;
        end
        check("R8 streams alternate", {31'd0, alternates}, 32'd1);
        first_side = 6'd0;
        for (int k = 0; k < 24; k++) begin
            if (pf_log[(base + k) % 1024] < 32'd4000) begin
                if (pf_log[(base + k) % 1024] != 32'(1004 + int'(first_side))) alternates = 1'b0;
                first_side = first_side + 6'd1;
            end
        end
        check("R2 unit stream order", {31'd0, alternates}, 32'd1);

        // R1: reset mid-stream drops pending work and history
        pf_ready = 1'b0;
        for (int k = 0; k < 4; k++) access(6'd7, 32'(300 + 3 * k));
        settle(2);
        check("R1 pending before reset", {31'd0, pf_valid}, 32'd1);
        do_reset();
        check("R1 idle after reset", {31'd0, pf_valid}, 32'd0);
        pf_ready = 1'b1;
        base = pf_cnt;
        access(6'd7, 32'd312);
        settle(20);
        check("R1 history cleared", 32'(pf_cnt - base), 32'd0);

        summary();
        $finish;
    end

endmodule